// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block keeps the most recently used logical-to-physical page translations for one access stream. A chip uses two copies, one beside the instruction fetch path and one beside the load/store path. Each cycle the stream presents a logical address, a supervisor/user flag and a read/write flag. Within the same cycle the block reports a hit or a miss. On a hit it returns the physical address, the cacheability field and the two user attribute bits of the matching entry. The protection bits are checked in that same cycle, so a forbidden access raises a fault and no valid physical address is released.

On a miss the block raises a walk request to an external table walker. The walker later returns a descriptor through the fill port, which supplies the logical address, the privilege flag, the physical page number and the attribute bits. The storage holds 64 entries, arranged as 16 sets of 4 ways. A configuration input selects 4 KB or 8 KB pages, and this choice decides which address bits form the page number. One synchronous input discards every translation in a single cycle.

Top module: `atc_top`

## Requirements
- R1: A lookup (lk_valid=1) is answered combinationally in the same cycle. A fill made on a clock edge is visible to lookups from the next cycle on, and a lookup in the cycle of the fill still sees the old contents.
- R2: With 4 KB pages (page_8k=0) the page number is lk_addr[31:12] and the set is lk_addr[15:12]. With 8 KB pages it is lk_addr[31:13] and the set is lk_addr[16:13]. An entry matches only a lookup with the same page number, the same supervisor flag and the same page size that it was filled with.
- R3: On an unfaulted hit, pa_valid=1. With 4 KB pages, pa = {ppn[19:0], lk_addr[11:0]}. With 8 KB pages, pa = {ppn[19:1], lk_addr[12:0]}. When pa_valid=0, pa is 0.
- R4: On a hit, cm_out and ua_out carry the entry's 2-bit cacheability and 2-bit user attributes, even when the access faults. Without a hit both are 0.
- R5: A write (lk_write=1) that hits an entry whose write-protect bit is set raises fault_wp and drops pa_valid.
- R6: A user-mode access (lk_super=0) that hits an entry whose supervisor-only bit is set raises fault_so and drops pa_valid. A supervisor access to a supervisor-tagged entry with that bit set does not fault.
- R7: walk_req = lk_valid and not hit. A miss gives hit=0, pa_valid=0 and no faults.
- R8: A fill that matches no stored entry goes to the lowest-numbered invalid way of its set. If all four ways are valid, it goes to the way named by that set's round-robin pointer. The pointer starts at way 0 and advances by one only on such a replacement.
- R9: A fill whose page, flag and size match an existing entry overwrites that entry in place. It does not move the pointer, so no lookup can ever match two ways.
- R10: inv_all clears every valid bit and every pointer in one cycle. It wins over a fill presented in the same cycle.
- R11: Four distinct pages that share a set are all held at once. A fifth page in a freshly filled set evicts the first one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| page_8k | input | 1 | 1 selects 8 KB pages, 0 selects 4 KB |
| inv_all | input | 1 | Invalidate every entry |
| lk_valid | input | 1 | Lookup present |
| lk_addr | input | 32 | Logical address of the lookup |
| lk_super | input | 1 | Lookup is in supervisor mode |
| lk_write | input | 1 | Lookup is a write |
| fill_valid | input | 1 | Descriptor fill present |
| fill_addr | input | 32 | Logical address the fill belongs to |
| fill_super | input | 1 | Privilege flag the fill is tagged with |
| fill_ppn | input | 20 | Physical page number in 4 KB units |
| fill_wp | input | 1 | Write-protect bit |
| fill_so | input | 1 | Supervisor-only bit |
| fill_cm | input | 2 | Cacheability field |
| fill_ua | input | 2 | User attribute bits |
| hit | output | 1 | Lookup matched an entry |
| pa_valid | output | 1 | Physical address usable (hit, no fault) |
| pa | output | 32 | Physical address |
| fault_wp | output | 1 | Write-protect violation |
| fault_so | output | 1 | Supervisor-only violation |
| cm_out | output | 2 | Cacheability of the matching entry |
| ua_out | output | 2 | User attributes of the matching entry |
| walk_req | output | 1 | Request to the table walker |

## Verification
The lookup is tried with addresses that differ only in the page offset, which shows that the offset is ignored and passed through. It is also tried with the same page under the other privilege flag and under the other page size, which shows that both are part of the tag. Pages are then packed into one set until it overflows and are refilled in place. This separates lowest-invalid-first placement from round-robin eviction and shows that an in-place refill leaves the pointer where it was. Reads and writes to protected entries under both privilege modes separate the two fault causes. An invalidate that coincides with a fill shows which of the two takes priority, and refilling afterwards shows that the pointers were reset.

// File: rtl/atc_pkg.sv
package atc_pkg;

   // Smallest page is 4 KB; 8 KB pages use one more offset bit.
   localparam int unsigned PG_SHIFT = 12;

   typedef struct packed {
      logic       wp;   // write protect
      logic       so;   // supervisor only
      logic [1:0] cm;   // cacheability
      logic [1:0] ua;   // user attributes
   } atc_attr_t;

   localparam int unsigned ATTR_W = $bits(atc_attr_t);

endpackage

// File: rtl/atc_index.sv
module atc_index
   import atc_pkg::*;
#(
   parameter int unsigned LA_W  = 32,
   parameter int unsigned IDX_W = 4,
   parameter int unsigned TAG_W = LA_W - PG_SHIFT - IDX_W + 2
) (
   input  logic [LA_W-1:0]  addr,
   input  logic             super_m,
   input  logic             big,
   output logic [IDX_W-1:0] set_o,
   output logic [TAG_W-1:0] tag_o
);

   localparam int unsigned HI_W = TAG_W - 2;

   logic [HI_W-1:0] hi_small;
   logic [HI_W-1:0] hi_big;

   // Tag bits above the set index for each page size.
   assign hi_small = addr[LA_W-1 -: HI_W];
   assign hi_big   = {1'b0, addr[LA_W-1 -: HI_W-1]};

   always_comb begin
      if (big) begin
         set_o = addr[PG_SHIFT+1 +: IDX_W];
         tag_o = {1'b1, super_m, hi_big};
      end else begin
         set_o = addr[PG_SHIFT +: IDX_W];
         tag_o = {1'b0, super_m, hi_small};
      end
   end

endmodule

// File: rtl/atc_way.sv
module atc_way
   import atc_pkg::*;
#(
   parameter int unsigned SETS  = 16,
   parameter int unsigned IDX_W = 4,
   parameter int unsigned TAG_W = 18,
   parameter int unsigned PPN_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inv,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_set,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [PPN_W-1:0] wr_ppn,
   input  atc_attr_t        wr_attr,
   input  logic [IDX_W-1:0] rd_set,
   input  logic [TAG_W-1:0] rd_tag,
   output logic             rd_hit,
   output logic [PPN_W-1:0] rd_ppn,
   output atc_attr_t        rd_attr,
   input  logic [IDX_W-1:0] pr_set,
   input  logic [TAG_W-1:0] pr_tag,
   output logic             pr_hit,
   output logic             pr_valid
);

   logic [SETS-1:0]  vld_q;
   logic [TAG_W-1:0] tag_q  [SETS];
   logic [PPN_W-1:0] ppn_q  [SETS];
   atc_attr_t        attr_q [SETS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (inv) begin
         vld_q <= '0;
      end else if (wr_en) begin
         vld_q[wr_set] <= 1'b1;
      end
   end

   // Payload needs no reset: it is only seen behind a valid bit.
   always_ff @(posedge clk) begin
      if (wr_en && !inv) begin
         tag_q[wr_set]  <= wr_tag;
         ppn_q[wr_set]  <= wr_ppn;
         attr_q[wr_set] <= wr_attr;
      end
   end

   assign rd_hit   = vld_q[rd_set] && (tag_q[rd_set] == rd_tag);
   assign rd_ppn   = ppn_q[rd_set];
   assign rd_attr  = attr_q[rd_set];
   assign pr_valid = vld_q[pr_set];
   assign pr_hit   = vld_q[pr_set] && (tag_q[pr_set] == pr_tag);

endmodule

// File: rtl/atc_victim.sv
module atc_victim #(
   parameter int unsigned SETS  = 16,
   parameter int unsigned IDX_W = 4,
   parameter int unsigned WAYS  = 4,
   parameter int unsigned WAY_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inv,
   input  logic             fill,
   input  logic [IDX_W-1:0] set_i,
   input  logic [WAYS-1:0]  valid_row,
   input  logic [WAYS-1:0]  match_row,
   output logic [WAYS-1:0]  sel
);

   logic [WAY_W-1:0] rr_q [SETS];
   logic [WAYS-1:0]  free_sel;
   logic [WAYS-1:0]  rr_sel;
   logic             any_free;
   logic             any_match;
   logic             use_rr;

   // Lowest-numbered invalid way wins: scan from the top down.
   always_comb begin
      free_sel = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (!valid_row[w]) begin
            free_sel    = '0;
            free_sel[w] = 1'b1;
         end
      end
   end

   assign any_free  = |(~valid_row);
   assign any_match = |match_row;
   assign rr_sel    = WAYS'(1) << rr_q[set_i];
   assign use_rr    = !any_match && !any_free;

   always_comb begin
      if (any_match)     sel = match_row;
      else if (any_free) sel = free_sel;
      else               sel = rr_sel;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || inv) begin
         for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
      end else if (fill && use_rr) begin
         rr_q[set_i] <= rr_q[set_i] + WAY_W'(1);
      end
   end

endmodule

// File: rtl/atc_top.sv
module atc_top
   import atc_pkg::*;
#(
   parameter int unsigned LA_W = 32,
   parameter int unsigned PA_W = 32,
   parameter int unsigned SETS = 16,
   parameter int unsigned WAYS = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   page_8k,
   input  logic                   inv_all,
   input  logic                   lk_valid,
   input  logic [LA_W-1:0]        lk_addr,
   input  logic                   lk_super,
   input  logic                   lk_write,
   input  logic                   fill_valid,
   input  logic [LA_W-1:0]        fill_addr,
   input  logic                   fill_super,
   input  logic [PA_W-PG_SHIFT-1:0] fill_ppn,
   input  logic                   fill_wp,
   input  logic                   fill_so,
   input  logic [1:0]             fill_cm,
   input  logic [1:0]             fill_ua,
   output logic                   hit,
   output logic                   pa_valid,
   output logic [PA_W-1:0]        pa,
   output logic                   fault_wp,
   output logic                   fault_so,
   output logic [1:0]             cm_out,
   output logic [1:0]             ua_out,
   output logic                   walk_req
);

   localparam int unsigned IDX_W = $clog2(SETS);
   localparam int unsigned WAY_W = $clog2(WAYS);
   localparam int unsigned TAG_W = LA_W - PG_SHIFT - IDX_W + 2;
   localparam int unsigned PPN_W = PA_W - PG_SHIFT;

   initial begin
      if (SETS < 2 || (1 << IDX_W) != SETS)
         $error("atc_top: SETS must be a power of two of at least 2");
      if (WAYS < 2 || (1 << WAY_W) != WAYS)
         $error("atc_top: WAYS must be a power of two of at least 2");
      if (LA_W < PG_SHIFT + IDX_W + 3)
         $error("atc_top: LA_W too small for the set index and tag");
      if (PA_W <= PG_SHIFT + 1)
         $error("atc_top: PA_W too small for an 8 KB frame");
   end

   // ---------------- address split ----------------
   logic [IDX_W-1:0] lk_set;
   logic [TAG_W-1:0] lk_tag;
   logic [IDX_W-1:0] fl_set;
   logic [TAG_W-1:0] fl_tag;

   atc_index #(.LA_W(LA_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_lk_idx (
      .addr    (lk_addr),
      .super_m (lk_super),
      .big     (page_8k),
      .set_o   (lk_set),
      .tag_o   (lk_tag)
   );

   atc_index #(.LA_W(LA_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_fl_idx (
      .addr    (fill_addr),
      .super_m (fill_super),
      .big     (page_8k),
      .set_o   (fl_set),
      .tag_o   (fl_tag)
   );

   // ---------------- ways ----------------
   logic             fill_en;
   atc_attr_t        fill_attr;
   logic [WAYS-1:0]  way_sel;
   logic [WAYS-1:0]  rd_hit_w;
   logic [WAYS-1:0]  hit_vec;
   logic [WAYS-1:0]  pr_hit_w;
   logic [WAYS-1:0]  pr_vld_w;
   logic [PPN_W-1:0] rd_ppn_w  [WAYS];
   atc_attr_t        rd_attr_w [WAYS];

   assign fill_en   = fill_valid && !inv_all;
   assign fill_attr = '{wp: fill_wp, so: fill_so, cm: fill_cm, ua: fill_ua};

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      atc_way #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_way (
         .clk      (clk),
         .rst_n    (rst_n),
         .inv      (inv_all),
         .wr_en    (fill_en && way_sel[w]),
         .wr_set   (fl_set),
         .wr_tag   (fl_tag),
         .wr_ppn   (fill_ppn),
         .wr_attr  (fill_attr),
         .rd_set   (lk_set),
         .rd_tag   (lk_tag),
         .rd_hit   (rd_hit_w[w]),
         .rd_ppn   (rd_ppn_w[w]),
         .rd_attr  (rd_attr_w[w]),
         .pr_set   (fl_set),
         .pr_tag   (fl_tag),
         .pr_hit   (pr_hit_w[w]),
         .pr_valid (pr_vld_w[w])
      );
   end

   atc_victim #(.SETS(SETS), .IDX_W(IDX_W), .WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
      .clk       (clk),
      .rst_n     (rst_n),
      .inv       (inv_all),
      .fill      (fill_en),
      .set_i     (fl_set),
      .valid_row (pr_vld_w),
      .match_row (pr_hit_w),
      .sel       (way_sel)
   );

   // ---------------- hit mux and protection ----------------
   logic [PPN_W-1:0] ppn_m;
   atc_attr_t        attr_m;
   logic [PA_W-1:0]  pa_small;
   logic [PA_W-1:0]  pa_big;

   assign hit_vec = rd_hit_w & {WAYS{lk_valid}};

   always_comb begin
      ppn_m  = '0;
      attr_m = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (hit_vec[w]) begin
            ppn_m  = ppn_m | rd_ppn_w[w];
            attr_m = attr_m | rd_attr_w[w];
         end
      end
   end

   assign pa_small = {ppn_m, lk_addr[PG_SHIFT-1:0]};
   assign pa_big   = {ppn_m[PPN_W-1:1], lk_addr[PG_SHIFT:0]};

   assign hit      = |hit_vec;
   assign fault_wp = hit && lk_write && attr_m.wp;
   assign fault_so = hit && !lk_super && attr_m.so;
   assign pa_valid = hit && !fault_wp && !fault_so;
   assign pa       = !pa_valid ? '0 : (page_8k ? pa_big : pa_small);
   assign cm_out   = attr_m.cm;
   assign ua_out   = attr_m.ua;
   assign walk_req = lk_valid && !hit;

endmodule

// File: rtl/atc_chk.sv
module atc_chk #(
   parameter int unsigned LA_W = 32,
   parameter int unsigned WAYS = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            page_8k,
   input logic            inv_all,
   input logic            lk_valid,
   input logic [LA_W-1:0] lk_addr,
   input logic            lk_super,
   input logic            lk_write,
   input logic            fill_valid,
   input logic [LA_W-1:0] fill_addr,
   input logic            fill_super,
   input logic            hit,
   input logic            pa_valid,
   input logic            fault_wp,
   input logic            fault_so,
   input logic            walk_req,
   input logic [WAYS-1:0] hit_vec
);

   // R1: a fill just written is found by the same address one cycle later
   a_r1_fill_visible: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(fill_valid) && !$past(inv_all) && $past(rst_n) && lk_valid
       && lk_addr == $past(fill_addr) && lk_super == $past(fill_super)
       && page_8k == $past(page_8k)) |-> hit);

   // R5: write-protect fault only on a write that hits
   a_r5_wp_cause: assert property (@(posedge clk) disable iff (!rst_n)
      fault_wp |-> (hit && lk_write && !pa_valid));

   // R6: supervisor-only fault only on a user access that hits
   a_r6_so_cause: assert property (@(posedge clk) disable iff (!rst_n)
      fault_so |-> (hit && !lk_super && !pa_valid));

   // R7: walk request never coexists with a hit
   a_r7_walk_excl: assert property (@(posedge clk) disable iff (!rst_n)
      walk_req |-> (lk_valid && !hit && !pa_valid));

   // R9: at most one way can match a lookup
   a_r9_no_dup: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   // R10: nothing hits right after an invalidate
   a_r10_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(inv_all) && $past(rst_n)) |-> !hit);

endmodule

bind atc_top atc_chk #(.LA_W(LA_W), .WAYS(WAYS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .page_8k    (page_8k),
   .inv_all    (inv_all),
   .lk_valid   (lk_valid),
   .lk_addr    (lk_addr),
   .lk_super   (lk_super),
   .lk_write   (lk_write),
   .fill_valid (fill_valid),
   .fill_addr  (fill_addr),
   .fill_super (fill_super),
   .hit        (hit),
   .pa_valid   (pa_valid),
   .fault_wp   (fault_wp),
   .fault_so   (fault_so),
   .walk_req   (walk_req),
   .hit_vec    (hit_vec)
);

// File: tb/atc_top_tb.sv
module atc_top_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        page_8k = 1'b0;
   logic        inv_all = 1'b0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_addr = '0;
   logic        lk_super = 1'b0;
   logic        lk_write = 1'b0;
   logic        fill_valid = 1'b0;
   logic [31:0] fill_addr = '0;
   logic        fill_super = 1'b0;
   logic [19:0] fill_ppn = '0;
   logic        fill_wp = 1'b0;
   logic        fill_so = 1'b0;
   logic [1:0]  fill_cm = '0;
   logic [1:0]  fill_ua = '0;
   logic        hit, pa_valid, fault_wp, fault_so, walk_req;
   logic [31:0] pa;
   logic [1:0]  cm_out, ua_out;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;   // 250 MHz

   atc_top u_dut (
      .clk(clk), .rst_n(rst_n), .page_8k(page_8k), .inv_all(inv_all),
      .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_super(lk_super), .lk_write(lk_write),
      .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_super(fill_super),
      .fill_ppn(fill_ppn), .fill_wp(fill_wp), .fill_so(fill_so), .fill_cm(fill_cm),
      .fill_ua(fill_ua), .hit(hit), .pa_valid(pa_valid), .pa(pa), .fault_wp(fault_wp),
      .fault_so(fault_so), .cm_out(cm_out), .ua_out(ua_out), .walk_req(walk_req)
   );

   // ---------------- behavioural reference ----------------
   bit          m_v   [16][4];
   longint      m_key [16][4];
   logic [19:0] m_ppn [16][4];
   logic [5:0]  m_at  [16][4];   // {wp, so, cm, ua}
   int          m_rr  [16];

   function automatic longint page_of(logic [31:0] a, bit b);
      return b ? longint'(a >> 13) : longint'(a >> 12);
   endfunction

   function automatic longint key_of(logic [31:0] a, bit s, bit b);
      return (longint'(b) << 40) | (longint'(s) << 39) | page_of(a, b);
   endfunction

   task automatic model_clear();
      for (int s = 0; s < 16; s++) begin
         m_rr[s] = 0;
         for (int w = 0; w < 4; w++) m_v[s][w] = 0;
      end
   endtask

   task automatic model_fill();
      longint k;
      int     s;
      int     tgt;
      k   = key_of(fill_addr, fill_super, page_8k);
      s   = int'(page_of(fill_addr, page_8k) & 15);
      tgt = -1;
      for (int w = 0; w < 4; w++) if (tgt < 0 && m_v[s][w] && m_key[s][w] == k) tgt = w;
      if (tgt < 0) for (int w = 0; w < 4; w++) if (tgt < 0 && !m_v[s][w]) tgt = w;
      if (tgt < 0) begin
         tgt     = m_rr[s];
         m_rr[s] = (m_rr[s] + 1) % 4;
      end
      m_v[s][tgt]   = 1;
      m_key[s][tgt] = k;
      m_ppn[s][tgt] = fill_ppn;
      m_at[s][tgt]  = {fill_wp, fill_so, fill_cm, fill_ua};
   endtask

   task automatic compare(string rq);
      bit          e_hit, e_pv, e_fw, e_fs, e_wr;
      logic [31:0] e_pa;
      logic [1:0]  e_cm, e_ua;
      longint      k;
      int          s;
      int          f;
      e_hit = 0; e_pa = '0; e_cm = '0; e_ua = '0; e_fw = 0; e_fs = 0; f = -1;
      if (lk_valid) begin
         k = key_of(lk_addr, lk_super, page_8k);
         s = int'(page_of(lk_addr, page_8k) & 15);
         for (int w = 0; w < 4; w++) if (m_v[s][w] && m_key[s][w] == k) f = w;
         if (f >= 0) begin
            e_hit = 1;
            e_cm  = m_at[s][f][3:2];
            e_ua  = m_at[s][f][1:0];
            e_fw  = lk_write && m_at[s][f][5];
            e_fs  = !lk_super && m_at[s][f][4];
            if (!e_fw && !e_fs)
               e_pa = page_8k ? {m_ppn[s][f][19:1], lk_addr[12:0]}
                              : {m_ppn[s][f], lk_addr[11:0]};
         end
      end
      e_pv = e_hit && !e_fw && !e_fs;
      e_wr = lk_valid && !e_hit;
      checks++;
      if ({hit, pa_valid, fault_wp, fault_so, walk_req, cm_out, ua_out} !==
          {e_hit, e_pv, e_fw, e_fs, e_wr, e_cm, e_ua} || pa !== e_pa) begin
         errors++;
         $display("FAIL %s: hit/pv/fwp/fso/walk/cm/ua/pa = %b%b%b%b%b %h %h %h, expected %b%b%b%b%b %h %h %h",
                  rq, hit, pa_valid, fault_wp, fault_so, walk_req, cm_out, ua_out, pa,
                  e_hit, e_pv, e_fw, e_fs, e_wr, e_cm, e_ua, e_pa);
      end
   endtask

   // Inputs are set just after a falling edge; step compares, clocks, updates.
   task automatic step(string rq);
      #1;
      compare(rq);
      @(posedge clk);
      if (!rst_n) model_clear();
      else if (inv_all) model_clear();
      else if (fill_valid) model_fill();
      @(negedge clk);
      lk_valid   = 1'b0;
      lk_write   = 1'b0;
      lk_super   = 1'b0;
      fill_valid = 1'b0;
      inv_all    = 1'b0;
   endtask

   task automatic set_fill(logic [31:0] a, bit s, logic [19:0] p, bit wp, bit so,
                           logic [1:0] cm, logic [1:0] ua);
      fill_valid = 1'b1; fill_addr = a; fill_super = s; fill_ppn = p;
      fill_wp = wp; fill_so = so; fill_cm = cm; fill_ua = ua;
   endtask

   task automatic set_look(logic [31:0] a, bit s, bit wr);
      lk_valid = 1'b1; lk_addr = a; lk_super = s; lk_write = wr;
   endtask

   task automatic fill(logic [31:0] a, bit s, logic [19:0] p, bit wp, bit so,
                       logic [1:0] cm, logic [1:0] ua, string rq);
      set_fill(a, s, p, wp, so, cm, ua);
      step(rq);
   endtask

   task automatic look(logic [31:0] a, bit s, bit wr, string rq);
      set_look(a, s, wr);
      step(rq);
   endtask

   initial begin
      repeat (300000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      model_clear();
      @(negedge clk);
      set_look(32'h0001_2345, 1'b0, 1'b0);
      step("R7");                       // during reset
      rst_n = 1'b1;
      look(32'h0001_2345, 1'b0, 1'b0, "R7");   // reset state: miss, walk
      look(32'h0001_2345, 1'b0, 1'b1, "R7");

      // R1: fill and look up in the same cycle sees old contents
      set_fill(32'h0001_2000, 1'b0, 20'hABCDE, 1'b0, 1'b0, 2'd2, 2'd3);
      set_look(32'h0001_2345, 1'b0, 1'b0);
      step("R1");
      look(32'h0001_2345, 1'b0, 1'b0, "R1");
      look(32'h0001_2FF0, 1'b0, 1'b1, "R3");
      look(32'h0001_2010, 1'b0, 1'b0, "R4");
      look(32'h0001_2345, 1'b1, 1'b0, "R2");   // other privilege flag
      look(32'h0001_3345, 1'b0, 1'b0, "R2");   // neighbouring page
      page_8k = 1'b1;
      look(32'h0001_2345, 1'b0, 1'b0, "R2");   // other page size
      fill(32'h0004_6ABC, 1'b0, 20'h12345, 1'b0, 1'b0, 2'd1, 2'd2, "R2");
      look(32'h0004_7FFF, 1'b0, 1'b0, "R3");
      look(32'h0004_6001, 1'b0, 1'b1, "R3");
      look(32'h0004_8001, 1'b0, 1'b0, "R2");
      page_8k = 1'b0;
      look(32'h0004_6ABC, 1'b0, 1'b0, "R2");

      // R5: write protection
      fill(32'h0010_3000, 1'b0, 20'h00077, 1'b1, 1'b0, 2'd1, 2'd1, "R5");
      look(32'h0010_3004, 1'b0, 1'b1, "R5");
      look(32'h0010_3004, 1'b0, 1'b0, "R5");
      look(32'h0010_3004, 1'b1, 1'b1, "R5");

      // R6: supervisor-only
      fill(32'h0020_4000, 1'b0, 20'h00088, 1'b0, 1'b1, 2'd3, 2'd0, "R6");
      look(32'h0020_4100, 1'b0, 1'b0, "R6");
      look(32'h0020_4100, 1'b0, 1'b1, "R6");
      fill(32'h0030_4000, 1'b1, 20'h00099, 1'b1, 1'b1, 2'd0, 2'd1, "R6");
      look(32'h0030_4200, 1'b1, 1'b0, "R6");
      look(32'h0030_4200, 1'b1, 1'b1, "R6");
      look(32'h0030_4200, 1'b0, 1'b0, "R6");

      // R11 / R8: fill one set beyond capacity
      for (int n = 1; n <= 4; n++)
         fill(32'h0000_7000 | (n << 20), 1'b0, 20'h50000 + n, 1'b0, 1'b0, 2'd0, 2'(n), "R8");
      for (int n = 1; n <= 4; n++)
         look(32'h0000_7010 | (n << 20), 1'b0, 1'b0, "R11");
      fill(32'h0050_7000, 1'b0, 20'h50005, 1'b0, 1'b0, 2'd1, 2'd1, "R11");
      look(32'h0010_7010, 1'b0, 1'b0, "R11");   // first page evicted
      look(32'h0050_7010, 1'b0, 1'b0, "R11");
      look(32'h0020_7010, 1'b0, 1'b0, "R8");
      fill(32'h0060_7000, 1'b0, 20'h50006, 1'b0, 1'b0, 2'd1, 2'd2, "R8");
      look(32'h0020_7010, 1'b0, 1'b0, "R8");   // second evicted

      // R9: refill in place keeps the pointer
      fill(32'h0050_7000, 1'b0, 20'h5AAAA, 1'b0, 1'b0, 2'd2, 2'd0, "R9");
      look(32'h0050_7020, 1'b0, 1'b0, "R9");
      fill(32'h0070_7000, 1'b0, 20'h50007, 1'b0, 1'b0, 2'd0, 2'd3, "R9");
      look(32'h0030_7010, 1'b0, 1'b0, "R9");   // third evicted
      look(32'h0040_7010, 1'b0, 1'b0, "R9");
      look(32'h0050_7010, 1'b0, 1'b0, "R9");

      // R10: invalidate beats a simultaneous fill
      inv_all = 1'b1;
      set_fill(32'h0080_9000, 1'b0, 20'h60000, 1'b0, 1'b0, 2'd1, 2'd1);
      step("R10");
      look(32'h0080_9000, 1'b0, 1'b0, "R10");
      look(32'h0001_2345, 1'b0, 1'b0, "R10");
      look(32'h0050_7010, 1'b0, 1'b0, "R10");
      for (int n = 1; n <= 5; n++)
         fill(32'h0000_7000 | (n << 24), 1'b0, 20'h70000 + n, 1'b0, 1'b0, 2'd0, 2'd0, "R10");
      look(32'h0100_7000, 1'b0, 1'b0, "R10");   // pointer restarted at way 0
      look(32'h0200_7000, 1'b0, 1'b0, "R10");
      look(32'h0500_7000, 1'b0, 1'b0, "R10");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule